// File: doc/BRIEF.md
# Root Port Error Message Collector

This block sits inside a root port and accepts error messages, each made of a severity class and a requester source ID, arriving either from devices below the port or from the port's own function. A message is admitted only when the port's forwarding and reporting enables allow it. The block then updates a root error status register with the "received" and "received more than once" flags for the correctable and uncorrectable classes. It also keeps a flag that marks a fatal error arriving as the first uncorrectable one, and a received flag for each uncorrectable severity.

The source ID of the first correctable and the first uncorrectable message is kept until software clears the matching received flag. The block requests an interrupt in one of two ways. With MSI enabled it emits a one-cycle request that carries the hardware-supplied message number. With MSI disabled it drives a level INTx line. Software writes the root error command register, which enables each class for interrupts, and clears status bits by writing ones. Building the MSI write and forwarding to an event collector are handled elsewhere.

Top module: `rec_collector`

## Requirements
- R1: A delivered correctable message (severity code 2'b00) sets status bit 0 (correctable received). If bit 0 was already set, it also sets bit 1 (multiple correctable). Otherwise it loads the correctable source ID output with the message's source ID.
- R2: A delivered uncorrectable message (severity 2'b01 non-fatal or 2'b10 fatal) sets status bit 2 (uncorrectable received). If bit 2 was already set, it also sets bit 3 (multiple uncorrectable). Otherwise it loads the uncorrectable source ID output.
- R3: A delivered fatal message sets bit 6 (fatal received) and, only when bit 2 was clear before it, bit 4 (first uncorrectable fatal). A delivered non-fatal message sets bit 5 (non-fatal received).
- R4: With MSI enabled, a delivered message raises an MSI request only when its class bit was previously clear and that class is enabled in the command register. The class bits are status bit 0, 5 or 6, and the enables are command bit 0 correctable, bit 1 non-fatal and bit 2 fatal.
- R5: With MSI disabled, a delivered message whose class is enabled in the command register drives INTx high. INTx changes only on such a message or on a command write.
- R6: On a command write with MSI enabled, an MSI is raised if any enable bit going 0 to 1 matches a set class status bit. With MSI disabled, INTx becomes the OR over classes of (new enable AND class status).
- R7: Reset clears the command register, all status bits, both source IDs, INTx and the MSI request. The message number output follows the hardware number input one cycle late.
- R8: A message is delivered only when the bridge forwarding enable, the command system-error enable and the device-control enable bit for its class are all set. Severity code 2'b11 is ignored. An undelivered message changes no status bit or source ID.
- R9: Every valid uncorrectable message gives a one-cycle received-system-error strobe. Such a message with both the bridge and command system-error enables set also gives a one-cycle signaled-system-error strobe.
- R10: A status write clears the bits written with 1. A hardware set of the same bit in the same cycle wins.
- R11: The MSI request lasts one cycle per triggering event and carries the current message number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Error message present this cycle |
| msg_sev | input | 2 | Severity: 00 correctable, 01 non-fatal, 10 fatal, 11 none |
| msg_src | input | 16 | Requester source ID of the message |
| bridge_fwd_en | input | 1 | Bridge control system-error forwarding enable |
| cmd_serr_en | input | 1 | Command register system-error enable |
| devctl_en | input | 3 | Device-control reporting enables {fatal, non-fatal, correctable} |
| msi_en | input | 1 | MSI enabled for the function |
| irq_num | input | 5 | Hardware-supplied interrupt message number |
| cmd_wr | input | 1 | Software write of the command register |
| cmd_wdata | input | 3 | New command value {fatal, non-fatal, correctable} |
| sts_wr | input | 1 | Software write-one-to-clear of the status register |
| sts_wdata | input | 7 | Bits to clear |
| root_cmd | output | 3 | Command register |
| root_sts | output | 7 | Status flags |
| root_num | output | 5 | Message number field of the status register |
| cor_src | output | 16 | Captured correctable source ID |
| uncor_src | output | 16 | Captured uncorrectable source ID |
| msi_req | output | 1 | One-cycle MSI request |
| msi_num | output | 5 | Message number carried by the request |
| intx | output | 1 | Level interrupt |
| rcv_serr | output | 1 | Received-system-error strobe |
| sig_serr | output | 1 | Signaled-system-error strobe |

## Verification
The assertions check on every cycle the rules that depend only on adjacent cycles. The multiple flags and the first-fatal flag may only rise when the stated earlier status holds. A source ID may only change while its received flag was clear. An MSI request is never issued with MSI disabled. The command register moves only on a write. The bench scenarios are needed to show what depends on combinations of enables and ordering: the rising-enable MSI, the INTx recompute on command writes, the gating, and the race between a clear and a hardware set of the same bit.

// File: rtl/rec_pkg.sv
`timescale 1ns/1ps
package rec_pkg;
    localparam int STS_W = 7;
    localparam int CLS_W = 3;

    localparam int B_COR    = 0;
    localparam int B_MCOR   = 1;
    localparam int B_UNC    = 2;
    localparam int B_MUNC   = 3;
    localparam int B_FFAT   = 4;
    localparam int B_NF     = 5;
    localparam int B_FAT    = 6;

    typedef enum logic [1:0] {
        SEV_COR  = 2'b00,
        SEV_NF   = 2'b01,
        SEV_FAT  = 2'b10,
        SEV_NONE = 2'b11
    } sev_e;

    function automatic logic [CLS_W-1:0] cls_of(input logic [STS_W-1:0] s);
        return {s[B_FAT], s[B_NF], s[B_COR]};
    endfunction
endpackage

// File: rtl/rec_gate.sv
`timescale 1ns/1ps
module rec_gate
    import rec_pkg::*;
(
    input  logic             valid,
    input  logic [1:0]       sev,
    input  logic             bridge_en,
    input  logic             serr_en,
    input  logic [CLS_W-1:0] dev_en,
    output logic [CLS_W-1:0] cls_hit,
    output logic             uncor_seen,
    output logic             uncor_sig
);
    logic [CLS_W-1:0] onehot;

    always_comb begin
        onehot = '0;
        if (valid) begin
            case (sev_e'(sev))
                SEV_COR: onehot = 3'b001;
                SEV_NF:  onehot = 3'b010;
                SEV_FAT: onehot = 3'b100;
                default: onehot = 3'b000;
            endcase
        end
        cls_hit    = (bridge_en && serr_en) ? (onehot & dev_en) : '0;
        uncor_seen = |onehot[2:1];
        uncor_sig  = uncor_seen && bridge_en && serr_en;
    end
endmodule

// File: rtl/rec_irq.sv
`timescale 1ns/1ps
module rec_irq
    import rec_pkg::*;
(
    input  logic             msi_en,
    input  logic [CLS_W-1:0] cmd_q,
    input  logic [CLS_W-1:0] cls_q,
    input  logic [CLS_W-1:0] cls_d,
    input  logic [CLS_W-1:0] cls_hit,
    input  logic             cmd_wr,
    input  logic [CLS_W-1:0] cmd_new,
    output logic             fire,
    output logic             lvl_wr,
    output logic             lvl
);
    logic [CLS_W-1:0] rise;

    always_comb begin
        rise   = cmd_wr ? (cmd_new & ~cmd_q) : '0;
        fire   = msi_en && ((|(cls_hit & ~cls_q & cmd_q)) || (|(rise & cls_d)));
        lvl_wr = 1'b0;
        lvl    = 1'b0;
        if (!msi_en) begin
            if (cmd_wr) begin
                lvl_wr = 1'b1;
                lvl    = |(cmd_new & cls_d);
            end else if (|(cls_hit & cmd_q)) begin
                lvl_wr = 1'b1;
                lvl    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rec_collector.sv
`timescale 1ns/1ps
module rec_collector
    import rec_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int NUM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic [1:0]       msg_sev,
    input  logic [SRC_W-1:0] msg_src,
    input  logic             bridge_fwd_en,
    input  logic             cmd_serr_en,
    input  logic [2:0]       devctl_en,
    input  logic             msi_en,
    input  logic [NUM_W-1:0] irq_num,
    input  logic             cmd_wr,
    input  logic [2:0]       cmd_wdata,
    input  logic             sts_wr,
    input  logic [6:0]       sts_wdata,
    output logic [2:0]       root_cmd,
    output logic [6:0]       root_sts,
    output logic [NUM_W-1:0] root_num,
    output logic [SRC_W-1:0] cor_src,
    output logic [SRC_W-1:0] uncor_src,
    output logic             msi_req,
    output logic [NUM_W-1:0] msi_num,
    output logic             intx,
    output logic             rcv_serr,
    output logic             sig_serr
);
    typedef struct packed {
        logic [CLS_W-1:0] cmd;
        logic [STS_W-1:0] sts;
        logic [SRC_W-1:0] csrc;
        logic [SRC_W-1:0] usrc;
        logic [NUM_W-1:0] num;
        logic             msi;
        logic             intx;
        logic             rse;
        logic             sse;
    } st_t;

    st_t st_q, st_d;

    logic [CLS_W-1:0] cls_hit;
    logic             uncor_seen, uncor_sig;
    logic [STS_W-1:0] set_v;
    logic             fire, lvl_wr, lvl;

    rec_gate u_gate (
        .valid      (msg_valid),
        .sev        (msg_sev),
        .bridge_en  (bridge_fwd_en),
        .serr_en    (cmd_serr_en),
        .dev_en     (devctl_en),
        .cls_hit    (cls_hit),
        .uncor_seen (uncor_seen),
        .uncor_sig  (uncor_sig)
    );

    always_comb begin
        set_v = '0;
        if (cls_hit[0]) begin
            set_v[B_COR] = 1'b1;
            if (st_q.sts[B_COR]) set_v[B_MCOR] = 1'b1;
        end
        if (cls_hit[1]) set_v[B_NF] = 1'b1;
        if (cls_hit[2]) begin
            set_v[B_FAT] = 1'b1;
            if (!st_q.sts[B_UNC]) set_v[B_FFAT] = 1'b1;
        end
        if (|cls_hit[2:1]) begin
            set_v[B_UNC] = 1'b1;
            if (st_q.sts[B_UNC]) set_v[B_MUNC] = 1'b1;
        end
    end

    rec_irq u_irq (
        .msi_en  (msi_en),
        .cmd_q   (st_q.cmd),
        .cls_q   (cls_of(st_q.sts)),
        .cls_d   (cls_of(st_d.sts)),
        .cls_hit (cls_hit),
        .cmd_wr  (cmd_wr),
        .cmd_new (cmd_wdata),
        .fire    (fire),
        .lvl_wr  (lvl_wr),
        .lvl     (lvl)
    );

    always_comb begin
        st_d     = st_q;
        st_d.num = irq_num;
        st_d.sts = (st_q.sts & ~(sts_wr ? sts_wdata : '0)) | set_v;
        if (cls_hit[0] && !st_q.sts[B_COR]) st_d.csrc = msg_src;
        if ((|cls_hit[2:1]) && !st_q.sts[B_UNC]) st_d.usrc = msg_src;
        if (cmd_wr) st_d.cmd = cmd_wdata;
        st_d.msi = fire;
        if (lvl_wr) st_d.intx = lvl;
        st_d.rse = uncor_seen;
        st_d.sse = uncor_sig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign root_cmd  = st_q.cmd;
    assign root_sts  = st_q.sts;
    assign root_num  = st_q.num;
    assign cor_src   = st_q.csrc;
    assign uncor_src = st_q.usrc;
    assign msi_req   = st_q.msi;
    assign msi_num   = st_q.num;
    assign intx      = st_q.intx;
    assign rcv_serr  = st_q.rse;
    assign sig_serr  = st_q.sse;
endmodule

// File: rtl/rec_chk.sv
`timescale 1ns/1ps
module rec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        msi_en,
    input logic        cmd_wr,
    input logic        msg_valid,
    input logic [2:0]  root_cmd,
    input logic [6:0]  root_sts,
    input logic [15:0] cor_src,
    input logic [15:0] uncor_src,
    input logic        msi_req
);
    assert_multi_cor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(root_sts[1]) |-> $past(root_sts[0]));

    assert_cor_src_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cor_src) |-> $past(!root_sts[0]));

    assert_multi_unc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(root_sts[3]) |-> $past(root_sts[2]));

    assert_unc_src_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(uncor_src) |-> $past(!root_sts[2]));

    assert_first_fatal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(root_sts[4]) |-> $past(!root_sts[2]) && root_sts[6]);

    assert_msi_only_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> $past(msi_en));

    assert_cmd_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cmd_wr) |-> $stable(root_cmd));

    assert_no_set_without_msg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!msg_valid) |-> ((root_sts & ~$past(root_sts)) == 7'd0));
endmodule

bind rec_collector rec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msi_en    (msi_en),
    .cmd_wr    (cmd_wr),
    .msg_valid (msg_valid),
    .root_cmd  (root_cmd),
    .root_sts  (root_sts),
    .cor_src   (cor_src),
    .uncor_src (uncor_src),
    .msi_req   (msi_req)
);

// File: tb/rec_collector_tb.sv
`timescale 1ns/1ps
module rec_collector_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msg_valid = 1'b0;
    logic [1:0] msg_sev = 2'b00;
    logic [15:0] msg_src = '0;
    logic bridge_fwd_en = 1'b0, cmd_serr_en = 1'b0;
    logic [2:0] devctl_en = '0;
    logic msi_en = 1'b0;
    logic [4:0] irq_num = '0;
    logic cmd_wr = 1'b0;
    logic [2:0] cmd_wdata = '0;
    logic sts_wr = 1'b0;
    logic [6:0] sts_wdata = '0;
    logic [2:0] root_cmd;
    logic [6:0] root_sts;
    logic [4:0] root_num, msi_num;
    logic [15:0] cor_src, uncor_src;
    logic msi_req, intx, rcv_serr, sig_serr;

    always #2.5 clk = ~clk;

    rec_collector u_dut (.*);

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [2:0]  m_cmd;
    logic [6:0]  m_sts;
    logic [4:0]  m_num;
    logic [15:0] m_cs, m_us;
    logic        m_msi, m_intx, m_rse, m_sse;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 cor flags/R10", {30'd0, root_sts[1:0]}, {30'd0, m_sts[1:0]});
        chk("R2 uncor flags/R10", {30'd0, root_sts[3:2]}, {30'd0, m_sts[3:2]});
        chk("R3 fatal flags/R10", {29'd0, root_sts[6:4]}, {29'd0, m_sts[6:4]});
        chk("R1 cor_src", {16'd0, cor_src}, {16'd0, m_cs});
        chk("R2 uncor_src", {16'd0, uncor_src}, {16'd0, m_us});
        chk("R4 R6 msi_req", {31'd0, msi_req}, {31'd0, m_msi});
        if (m_msi) chk("R11 msi_num", {27'd0, msi_num}, {27'd0, m_num});
        chk("R5 R6 intx", {31'd0, intx}, {31'd0, m_intx});
        chk("R6 root_cmd", {29'd0, root_cmd}, {29'd0, m_cmd});
        chk("R7 root_num", {27'd0, root_num}, {27'd0, m_num});
        chk("R9 rcv_serr", {31'd0, rcv_serr}, {31'd0, m_rse});
        chk("R9 sig_serr", {31'd0, sig_serr}, {31'd0, m_sse});
    endtask

    function automatic logic [2:0] cls(input logic [6:0] s);
        return {s[6], s[5], s[0]};
    endfunction

    // Next-state model written from the requirements.
    task automatic model_step();
        logic [2:0] hit, oh, rise;
        logic [6:0] setv, nsts;
        logic uv;
        oh = 3'b000;
        if (msg_valid && msg_sev != 2'b11) oh = 3'b001 << msg_sev;
        hit = (bridge_fwd_en && cmd_serr_en) ? (oh & devctl_en) : 3'b000;
        uv = oh[1] | oh[2];
        setv = '0;
        if (hit[0]) begin setv[0] = 1; if (m_sts[0]) setv[1] = 1; end
        if (hit[1]) setv[5] = 1;
        if (hit[2]) begin setv[6] = 1; if (!m_sts[2]) setv[4] = 1; end
        if (hit[1] | hit[2]) begin setv[2] = 1; if (m_sts[2]) setv[3] = 1; end
        nsts = (m_sts & ~(sts_wr ? sts_wdata : 7'd0)) | setv;
        if (hit[0] && !m_sts[0]) m_cs = msg_src;
        if ((hit[1] | hit[2]) && !m_sts[2]) m_us = msg_src;
        rise = cmd_wr ? (cmd_wdata & ~m_cmd) : 3'b000;
        m_msi = msi_en && ((|(hit & ~cls(m_sts) & m_cmd)) || (|(rise & cls(nsts))));
        if (!msi_en) begin
            if (cmd_wr) m_intx = |(cmd_wdata & cls(nsts));
            else if (|(hit & m_cmd)) m_intx = 1'b1;
        end
        if (cmd_wr) m_cmd = cmd_wdata;
        m_sts = nsts;
        m_num = irq_num;
        m_rse = uv;
        m_sse = uv && bridge_fwd_en && cmd_serr_en;
    endtask

    task automatic cycle();
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        msg_valid = 0; cmd_wr = 0; sts_wr = 0;
    endtask

    task automatic send(input logic [1:0] sev, input logic [15:0] src);
        msg_valid = 1; msg_sev = sev; msg_src = src;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        m_cmd = 0; m_sts = 0; m_num = 0; m_cs = 0; m_us = 0;
        m_msi = 0; m_intx = 0; m_rse = 0; m_sse = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare_all(); // R7 reset state

        // Directed: full enables, MSI on, enable all classes.
        bridge_fwd_en = 1; cmd_serr_en = 1; devctl_en = 3'b111;
        msi_en = 1; irq_num = 5'd17;
        cmd_wr = 1; cmd_wdata = 3'b111; cycle(); idle();
        send(2'b00, 16'h0101); cycle();        // R1 first cor, R4 msi
        send(2'b00, 16'h0202); cycle();        // R1 multiple, no msi
        send(2'b10, 16'h0303); cycle();        // R3 first fatal, R2
        send(2'b01, 16'h0404); cycle();        // R2 multiple
        idle(); cycle();
        // R10: clear cor while a new cor arrives
        send(2'b00, 16'h0505); sts_wr = 1; sts_wdata = 7'h7f; cycle(); idle(); cycle();
        // R8: gated message
        bridge_fwd_en = 0; send(2'b10, 16'h0606); cycle(); idle(); cycle();
        bridge_fwd_en = 1; send(2'b11, 16'h0707); cycle(); idle(); cycle();
        // R6: rising enable with pending status, MSI on then INTx
        cmd_wr = 1; cmd_wdata = 3'b000; cycle(); idle(); cycle();
        cmd_wr = 1; cmd_wdata = 3'b001; cycle(); idle(); cycle();
        msi_en = 0;
        cmd_wr = 1; cmd_wdata = 3'b100; cycle(); idle(); cycle();
        cmd_wr = 1; cmd_wdata = 3'b000; cycle(); idle(); cycle();
        send(2'b01, 16'h0808); cycle(); idle(); cycle();  // R5 disabled class: intx stays

        // Constrained random phase.
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) msi_en = $urandom_range(0, 1);
            msg_valid     = $urandom_range(0, 1);
            msg_sev       = 2'($urandom_range(0, 3));
            msg_src       = 16'($urandom);
            bridge_fwd_en = $urandom_range(0, 9) != 0;
            cmd_serr_en   = $urandom_range(0, 9) != 0;
            devctl_en     = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b111;
            irq_num       = ($urandom_range(0, 31) == 0) ? 5'($urandom) : irq_num;
            cmd_wr        = $urandom_range(0, 9) == 0;
            cmd_wdata     = 3'($urandom);
            sts_wr        = $urandom_range(0, 6) == 0;
            sts_wdata     = 7'($urandom);
            cycle();
        end
        idle(); cycle();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule